// File: doc/BRIEF.md
# Serial-Port Byte Access to a Shared Frame Buffer

This block is a serial slave front end. Through it an external host reads and writes single bytes, or runs of consecutive bytes, in a 128-byte frame buffer and in a small window that belongs to a security engine. The frame buffer is shared by the receive and transmit paths, so a frame arriving off the air may overwrite transmit data. An optional protection scheme guards a frame that is being received against host writes.

Each transaction runs while the active-low select is held low. The host first shifts in a command byte, then a start address, then any number of data bytes. On a write the data bytes come in on the serial input. On a read they go out on the serial output. The address steps by one after every data byte. The serial pins are sampled by the system clock through synchronizers. The buffer itself sits outside the block, behind a simple byte port with a one-cycle read latency. A write that protection refuses is dropped, and it raises a one-cycle violation interrupt.

Top module: `sfb_spi_sram`

## Requirements
- R1: While select is high, `spi_miso_oe` is 0 and `spi_miso` is 0. While select is low, `spi_miso_oe` is 1.
- R2: The first byte is the command. Value 0x40 (bit 6 = 1, bit 5 = 0, all other bits 0) starts a read, and value 0x60 starts a write. Any other value makes the block ignore the rest of the transaction: it does no memory access, raises no violation, and drives 0 on `spi_miso`.
- R3: The second byte is the start address. On a write, each byte from the third one onward is stored at the current address, and the address then increments by one, wrapping from 0xFF to 0x00.
- R4: On a read, the bytes from the third one onward carry the data at the start address and at each following address, in SPI mode 0 with MSB first. The block samples the input on rising serial-clock edges and changes the output after falling edges.
- R5: The legal addresses are 0x00–0x7F (frame buffer) and 0x82–0x94 (security window). A write to any other address is dropped, and a read of any other address returns 0x00.
- R6: While `prot_en` and `rx_busy` are both 1, a write data byte aimed at 0x00–0x7F is not stored and raises `viol_irq` for exactly one clock cycle. Writes to the security window still go through.
- R7: Reads are never blocked and never raise `viol_irq`, whatever the values of `prot_en` and `rx_busy`.
- R8: Raising select ends the transaction at once and discards any partial byte. The next transaction decodes its first byte as a command again.
- R9: The memory port never asserts read and write in the same cycle, and a write strobe always carries a legal address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_sel_n | input | 1 | Transaction select, active low |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| prot_en | input | 1 | Frame-buffer write protection enabled |
| rx_busy | input | 1 | A frame is currently being received |
| mem_addr | output | 8 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |
| viol_irq | output | 1 | One-cycle pulse on a refused write |

## Verification
The bench builds the block with its default windows (frame buffer up to 0x7F, security window 0x82–0x94) and with three synchronizer stages instead of two. The extra stage adds latency on every serial edge. With a serial half period of eight system clocks, the read prefetch and the first output bit still have to fit within one half period. Against these defaults, boundary transfers that run across 0x7F/0x80 and 0x94/0x95 show both window edges. Holding protection and receive-busy in each combination separates the blocked frame-buffer writes from the security-window writes and from the reads, which stay unblocked.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned BIT_W   = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] CMD_MASK  = 8'hDF;
    localparam logic [BYTE_W-1:0] CMD_MATCH = 8'h40;
    localparam int unsigned       CMD_WR_BIT = 5;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic [BIT_W-1:0]  bit_cnt;
        phase_e            phase;
        logic              ignore;
        logic              is_wr;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] tx_sh;
        logic [ADDR_W-1:0] addr;
        logic              fetch_pend;
        logic              miso;
        logic              oe;
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] mem_addr;
        logic [BYTE_W-1:0] wdata;
        logic              viol;
        logic              sclk_prev;
    } sfb_state_t;
endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sfb_window.sv
module sfb_window
    import sfb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FB_LAST   = 8'h7F,
    parameter logic [ADDR_W-1:0] SEC_FIRST = 8'h82,
    parameter logic [ADDR_W-1:0] SEC_LAST  = 8'h94
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_en,
    input  logic              rx_busy,
    output logic              legal,
    output logic              blocked
);
    logic fb_hit;
    logic sec_hit;

    always_comb begin
        fb_hit  = (addr <= FB_LAST);
        sec_hit = (addr >= SEC_FIRST) && (addr <= SEC_LAST);
        legal   = fb_hit || sec_hit;
        blocked = fb_hit && prot_en && rx_busy;
    end
endmodule

// File: rtl/sfb_spi_sram.sv
module sfb_spi_sram
    import sfb_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] FB_LAST     = 8'h7F,
    parameter logic [ADDR_W-1:0] SEC_FIRST   = 8'h82,
    parameter logic [ADDR_W-1:0] SEC_LAST    = 8'h94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_sel_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              prot_en,
    input  logic              rx_busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              viol_irq
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic [2:0] pins_s;
    logic       sclk_s;
    logic       mosi_s;
    logic       sel_n_s;

    sfb_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sel_n, spi_mosi, spi_sclk}),
        .dout  (pins_s)
    );

    assign sclk_s  = pins_s[0];
    assign mosi_s  = pins_s[1];
    assign sel_n_s = pins_s[2];

    sfb_state_t q, d;

    logic              rise;
    logic              fall;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_rcv;
    logic [ADDR_W-1:0] win_addr;
    logic              win_legal;
    logic              win_blocked;

    sfb_window #(
        .FB_LAST   (FB_LAST),
        .SEC_FIRST (SEC_FIRST),
        .SEC_LAST  (SEC_LAST)
    ) u_window (
        .addr    (win_addr),
        .prot_en (prot_en),
        .rx_busy (rx_busy),
        .legal   (win_legal),
        .blocked (win_blocked)
    );

    // Edge detection and the address the window decoder must judge this cycle.
    always_comb begin
        rise      = sclk_s && !q.sclk_prev;
        fall      = !sclk_s && q.sclk_prev;
        byte_rcv  = {q.rx_sh[BYTE_W-2:0], mosi_s};
        byte_done = rise && (q.bit_cnt == LAST_BIT) && !sel_n_s && !q.ignore;
        case (q.phase)
            PH_ADDR: win_addr = byte_rcv;
            PH_DATA: win_addr = q.is_wr ? q.addr : q.addr + 1'b1;
            default: win_addr = byte_rcv;
        endcase
    end

    always_comb begin
        d            = q;
        d.we         = 1'b0;
        d.re         = 1'b0;
        d.viol       = 1'b0;
        d.fetch_pend = q.re;
        d.sclk_prev  = sclk_s;

        if (sel_n_s) begin
            d.bit_cnt    = '0;
            d.phase      = PH_CMD;
            d.ignore     = 1'b0;
            d.is_wr      = 1'b0;
            d.rx_sh      = '0;
            d.tx_sh      = '0;
            d.miso       = 1'b0;
            d.oe         = 1'b0;
            d.fetch_pend = 1'b0;
        end else begin
            d.oe = 1'b1;
            if (rise) begin
                d.rx_sh   = byte_rcv;
                d.bit_cnt = q.bit_cnt + 1'b1;
            end
            if (fall) begin
                d.miso  = q.tx_sh[BYTE_W-1];
                d.tx_sh = {q.tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (q.fetch_pend) begin
                d.tx_sh = mem_rdata;
            end
            if (byte_done) begin
                case (q.phase)
                    PH_CMD: begin
                        if ((byte_rcv & CMD_MASK) == CMD_MATCH) begin
                            d.is_wr = byte_rcv[CMD_WR_BIT];
                            d.phase = PH_ADDR;
                        end else begin
                            d.ignore = 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        d.addr  = byte_rcv;
                        d.phase = PH_DATA;
                        if (!q.is_wr) begin
                            if (win_legal) begin
                                d.re       = 1'b1;
                                d.mem_addr = byte_rcv;
                            end else begin
                                d.tx_sh = '0;
                            end
                        end
                    end
                    default: begin
                        d.addr = q.addr + 1'b1;
                        if (q.is_wr) begin
                            if (win_blocked) begin
                                d.viol = 1'b1;
                            end else if (win_legal) begin
                                d.we       = 1'b1;
                                d.mem_addr = q.addr;
                                d.wdata    = byte_rcv;
                            end
                        end else if (win_legal) begin
                            d.re       = 1'b1;
                            d.mem_addr = q.addr + 1'b1;
                        end else begin
                            d.tx_sh = '0;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= PH_CMD;
        end else begin
            q <= d;
        end
    end

    assign spi_miso    = q.miso;
    assign spi_miso_oe = q.oe;
    assign mem_addr    = q.mem_addr;
    assign mem_we      = q.we;
    assign mem_wdata   = q.wdata;
    assign mem_re      = q.re;
    assign viol_irq    = q.viol;

    // R1: output released one cycle after the synchronized select goes high
    a_r1_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (!spi_miso_oe && !spi_miso));

    // R6: a violation is a single-cycle pulse
    a_r6_viol_single: assert property (@(posedge clk) disable iff (!rst_n)
        viol_irq |=> !viol_irq);

    // R6: no frame-buffer write lands while the buffer was guarded
    a_r6_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(prot_en && rx_busy)) |-> (mem_addr > FB_LAST));

    // R9: a write strobe always carries an address inside a legal window
    a_r9_write_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr <= FB_LAST) ||
                    ((mem_addr >= SEC_FIRST) && (mem_addr <= SEC_LAST))));

    // R9: read and write strobes are exclusive
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    // R7: a violation never follows a read strobe
    a_r7_read_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> !viol_irq);
endmodule

// File: tb/tb_sfb_spi_sram.sv
module tb_sfb_spi_sram;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       sel_n = 1'b1;
    logic       miso;
    logic       miso_oe;
    logic       prot_en = 1'b0;
    logic       rx_busy = 1'b0;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic       mem_re;
    logic [7:0] mem_rdata;
    logic       viol;

    always #2 clk = ~clk;

    sfb_spi_sram #(
        .SYNC_STAGES (3),
        .FB_LAST     (8'h7F),
        .SEC_FIRST   (8'h82),
        .SEC_LAST    (8'h94)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_mosi    (mosi),
        .spi_sel_n   (sel_n),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .prot_en     (prot_en),
        .rx_busy     (rx_busy),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_re      (mem_re),
        .mem_rdata   (mem_rdata),
        .viol_irq    (viol)
    );

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] rdata_q = 8'h00;
    int         viol_cnt = 0;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) rdata_q <= mem[mem_addr];
        if (viol) viol_cnt <= viol_cnt + 1;
    end
    assign mem_rdata = rdata_q;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [7:0] dbuf [8];

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal_addr(input logic [7:0] a);
        return (a <= 8'h7F) || (a >= 8'h82 && a <= 8'h94);
    endfunction

    function automatic bit guarded(input logic [7:0] a, input bit p, input bit b);
        return (a <= 8'h7F) && p && b;
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            mosi = tx[i];
            repeat (HP) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
        end
    endtask

    task automatic end_txn();
        sclk = 1'b0;
        repeat (HP) @(negedge clk);
        sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // One full transaction with the model updated and every byte checked.
    task automatic txn(input logic [7:0] cmd, input logic [7:0] a0, input int n,
                       input bit p, input bit b, input string req);
        logic [7:0] rx;
        logic [7:0] a;
        int v0;
        int vexp;
        bit ok;
        bit wr;
        ok   = ((cmd & 8'hDF) == 8'h40);
        wr   = cmd[5];
        vexp = 0;
        prot_en = p;
        rx_busy = b;
        v0 = viol_cnt;
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HP) @(negedge clk);
        check("R1", miso_oe, 1, "oe while selected");
        xfer(cmd, rx);
        check("R2", rx, 0, "miso in command byte");
        xfer(a0, rx);
        a = a0;
        for (int k = 0; k < n; k++) begin
            if (ok && wr) begin
                xfer(dbuf[k], rx);
                if (guarded(a, p, b)) vexp++;
                else if (legal_addr(a)) exp_mem[a] = dbuf[k];
            end else begin
                xfer(8'h00, rx);
                if (!ok) check("R2", rx, 0, "ignored command read data");
                else if (legal_addr(a)) check("R4", rx, exp_mem[a], "read data");
                else check("R5", rx, 0, "out-of-window read");
            end
            a = a + 8'd1;
        end
        end_txn();
        check("R1", miso_oe, 0, "oe after release");
        check("R6", viol_cnt - v0, vexp, $sformatf("%s violation count", req));
        for (int j = 0; j < 256; j++) begin
            if (mem[j] != exp_mem[j]) begin
                check(req, mem[j], exp_mem[j], $sformatf("memory byte %0h", j));
                break;
            end
        end
        checks++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        void'($urandom(32'h5EED1234));
        for (int j = 0; j < 256; j++) begin
            mem[j]     = 8'($urandom);
            exp_mem[j] = mem[j];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", miso_oe, 0, "oe after reset");
        check("R1", miso, 0, "miso after reset");
        check("R9", mem_we, 0, "we after reset");
        check("R6", viol, 0, "viol after reset");

        // R3: write a run, then R4: read it back
        for (int k = 0; k < 4; k++) dbuf[k] = 8'hA0 + 8'(k);
        txn(8'h60, 8'h10, 4, 1'b0, 1'b0, "R3");
        txn(8'h40, 8'h10, 4, 1'b0, 1'b0, "R4");
        // R5: run across frame-buffer end and security window edges
        for (int k = 0; k < 5; k++) dbuf[k] = 8'h5A ^ 8'(k);
        txn(8'h60, 8'h7E, 5, 1'b0, 1'b0, "R5");
        txn(8'h40, 8'h7E, 5, 1'b0, 1'b0, "R5");
        txn(8'h60, 8'h92, 5, 1'b0, 1'b0, "R5");
        txn(8'h40, 8'h92, 5, 1'b0, 1'b0, "R5");
        txn(8'h40, 8'hFE, 3, 1'b0, 1'b0, "R3");
        // R6: guarded writes refused, security writes kept, protection off without busy
        txn(8'h60, 8'h7E, 5, 1'b1, 1'b1, "R6");
        txn(8'h60, 8'h20, 3, 1'b1, 1'b0, "R6");
        txn(8'h60, 8'h20, 3, 1'b0, 1'b1, "R6");
        // R7: reads under guard still return data, no violation
        txn(8'h40, 8'h00, 3, 1'b1, 1'b1, "R7");
        // R2: non-matching commands ignored
        txn(8'h00, 8'h10, 2, 1'b0, 1'b0, "R2");
        txn(8'hC0, 8'h10, 2, 1'b0, 1'b0, "R2");
        txn(8'h41, 8'h10, 2, 1'b0, 1'b0, "R2");
        txn(8'h20, 8'h10, 2, 1'b0, 1'b0, "R2");
        txn(8'h70, 8'h10, 2, 1'b0, 1'b0, "R2");

        // R8: abort mid command, then after an address, then a normal write
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 5; i--) begin
            sclk = 1'b0; mosi = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
        end
        end_txn();
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HP) @(negedge clk);
        xfer(8'h60, rx);
        xfer(8'h30, rx);
        for (int i = 7; i >= 4; i--) begin
            sclk = 1'b0; mosi = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
        end
        end_txn();
        check("R8", mem[8'h30], exp_mem[8'h30], "partial byte discarded");
        dbuf[0] = 8'h3C;
        txn(8'h60, 8'h31, 1, 1'b0, 1'b0, "R8");
        txn(8'h40, 8'h30, 2, 1'b0, 1'b0, "R8");

        // Random mix
        for (int t = 0; t < 60; t++) begin
            logic [7:0] c;
            logic [7:0] a;
            int sel;
            int n;
            sel = int'($urandom_range(0, 9));
            c = (sel < 4) ? 8'h40 : (sel < 8) ? 8'h60 : 8'($urandom);
            a = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(8'h70, 8'h98)) : 8'($urandom);
            n = int'($urandom_range(1, 6));
            for (int k = 0; k < 8; k++) dbuf[k] = 8'($urandom);
            txn(c, a, n, 1'($urandom), 1'($urandom), "R3");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule